// File: doc/BRIEF.md
# Banked Word-Addressed Memory with Per-Bank Gating

This block is a synchronous memory of 1 Mbit holding 32-bit words. Storage is divided into 32 identical banks, each of 128 rows that are 256 bits wide, so every row carries eight words. A 15-bit word address is split into three fields. The upper field names a bank, the middle field names a row in that bank, and the low field names one word inside the row. The read strobe, the write strobe, the address and the write data are first captured in an input register. Only the addressed bank is then enabled. Every other bank receives no enable and keeps its contents, its output register and its counter unchanged.

Each bank has its own output register, which latches the selected word when that bank serves a read. A one-hot ownership register records which bank served the most recent read. Only that bank's register reaches the shared read-data port, which acts as a one-hot multiplexer standing in for a tri-state bus. Each bank also counts the cycles in which it was enabled. This count lets the surrounding system, or a bench, prove that idle banks stayed idle. A request that asks for a read and a write together is rejected, and an error output flags it.

Top module: `sram_banked`

## Requirements
- R1: After reset, `rdata_o` is zero, `err_o` is low and every bank activity counter is zero.
- R2: Address bits [14:10] select the bank, bits [9:3] select the row and bits [2:0] select the word. Word w occupies row bits [32w+31:32w]. Locations that differ in any one field are independent.
- R3: A write changes only the addressed 32-bit word. The other seven words of the same row keep their values.
- R4: A read presented at rising edge N (captured there) shows its word on `rdata_o` after edge N+1, and not earlier.
- R5: `rdata_o` keeps its last value while no read is being served, which covers writes, idle cycles and rejected requests.
- R6: Every accepted read or write adds one to the addressed bank's counter, which is `act_cnt_o[16b+15:16b]` for bank b. All other counters are unchanged, and at most one bank is enabled in a cycle.
- R7: A request with read and write both high, captured at edge N, drives `err_o` high for the cycle after edge N. It writes no memory, touches no counter and leaves `rdata_o` unchanged.
- R8: At most one bank drives the shared read-data bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| addr_i | input | 15 | Word address: bank, row, word fields |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data from the owning bank |
| err_o | output | 1 | Rejected request (read and write together) |
| act_cnt_o | output | 512 | 32 enable counters of 16 bits each, bank b at [16b+15:16b] |

## Verification
A read and a write can be requested in the same cycle. The bench provokes this with directed collisions on addresses whose contents are known, and with about one request in ten of its seeded random stream. A collision is judged in four ways. `err_o` must be high exactly one cycle after capture. The read port must keep its previous word. No bank counter may move. A later read of the targeted address must return the data written before the collision.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;

    // Decoded request kind held in the input register
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CLASH = 2'd3
    } op_e;

    function automatic op_e classify(input logic rd, input logic wr);
        op_e k;
        unique case ({rd, wr})
            2'b10:   k = OP_READ;
            2'b01:   k = OP_WRITE;
            2'b11:   k = OP_CLASH;
            default: k = OP_IDLE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/sram_req_reg.sv
module sram_req_reg
    import sram_bank_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] wdata_o
);

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d       = req_q;
        req_d.op    = classify(rd_i, wr_i);
        req_d.addr  = addr_i;
        req_d.wdata = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '{op: OP_IDLE, addr: '0, wdata: '0};
        end else begin
            req_q <= req_d;
        end
    end

    assign op_o    = req_q.op;
    assign addr_o  = req_q.addr;
    assign wdata_o = req_q.wdata;

endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
    parameter int ROWS   = 128,
    parameter int ROW_W  = 256,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int WPR    = ROW_W / WORD_W,
    localparam int COL_W  = $clog2(WPR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_i,
    input  logic [ROW_AW-1:0] row_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic [CNT_W-1:0]  cnt_o
);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic [CNT_W-1:0]  cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [ROW_W-1:0]  mem_q [ROWS];
    logic [ROW_W-1:0]  row_data;
    logic [WORD_W-1:0] word_sel;

    // Word selection over the addressed row (8-to-1 by default)
    always_comb begin
        row_data = mem_q[row_i];
        word_sel = '0;
        for (int w = 0; w < WPR; w++) begin
            if (col_i == COL_W'(w)) begin
                word_sel = row_data[w*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (!wr_i) begin
                st_d.rdata = word_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Array update: only the addressed word group of the row (R3)
    always_ff @(posedge clk) begin
        if (en_i && wr_i) begin
            for (int w = 0; w < WPR; w++) begin
                if (col_i == COL_W'(w)) begin
                    mem_q[row_i][w*WORD_W +: WORD_W] <= wdata_i;
                end
            end
        end
    end

    assign rdata_o = st_q.rdata;
    assign cnt_o   = st_q.cnt;

    p_idle_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(st_q));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    p_write_keeps_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_i) |=> $stable(st_q.rdata));

endmodule

// File: rtl/sram_bus_mux.sv
module sram_bus_mux #(
    parameter int N = 32,
    parameter int W = 32
) (
    input  logic [N-1:0]   sel_i,
    input  logic [N*W-1:0] data_i,
    output logic [W-1:0]   data_o
);

    // One-hot select stands in for a shared tri-state bus
    always_comb begin
        data_o = '0;
        for (int b = 0; b < N; b++) begin
            if (sel_i[b]) begin
                data_o = data_o | data_i[b*W +: W];
            end
        end
    end

endmodule

// File: rtl/sram_banked.sv
module sram_banked
    import sram_bank_pkg::*;
#(
    parameter int BANKS  = 32,
    parameter int ROWS   = 128,
    parameter int ROW_W  = 256,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_AW = $clog2(ROWS),
    localparam int COL_W  = $clog2(ROW_W / WORD_W),
    localparam int ADDR_W = BANK_W + ROW_AW + COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_i,
    input  logic                   wr_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [WORD_W-1:0]      wdata_i,
    output logic [WORD_W-1:0]      rdata_o,
    output logic                   err_o,
    output logic [BANKS*CNT_W-1:0] act_cnt_o
);

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;

    sram_req_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (rd_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .op_o    (op_q),
        .addr_o  (addr_q),
        .wdata_o (wdata_q)
    );

    // Address fields: bank | row | word (R2)
    logic [BANK_W-1:0] bank_sel;
    logic [ROW_AW-1:0] row_sel;
    logic [COL_W-1:0]  col_sel;
    logic              access;
    logic [BANKS-1:0]  bank_en;

    assign bank_sel = addr_q[ADDR_W-1 -: BANK_W];
    assign row_sel  = addr_q[COL_W +: ROW_AW];
    assign col_sel  = addr_q[COL_W-1:0];
    assign access   = (op_q == OP_READ) || (op_q == OP_WRITE);

    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_en[b] = access && (bank_sel == BANK_W'(b));
        end
    end

    logic [BANKS*WORD_W-1:0] bank_rdata;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sram_bank #(
            .ROWS   (ROWS),
            .ROW_W  (ROW_W),
            .WORD_W (WORD_W),
            .CNT_W  (CNT_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (bank_en[b]),
            .wr_i    (op_q == OP_WRITE),
            .row_i   (row_sel),
            .col_i   (col_sel),
            .wdata_i (wdata_q),
            .rdata_o (bank_rdata[b*WORD_W +: WORD_W]),
            .cnt_o   (act_cnt_o[b*CNT_W +: CNT_W])
        );
    end

    // Bus ownership passes to the bank that served the latest read
    typedef struct packed {
        logic [BANKS-1:0] owner;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op_q == OP_READ) begin
            st_d.owner = bank_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sram_bus_mux #(.N(BANKS), .W(WORD_W)) u_bus (
        .sel_i  (st_q.owner),
        .data_i (bank_rdata),
        .data_o (rdata_o)
    );

    assign err_o = (op_q == OP_CLASH);

    p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.owner));

    p_one_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en));

    p_clash_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (bank_en == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q != OP_READ) |=> $stable(rdata_o));

    p_read_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_READ) |=> $onehot(st_q.owner));

endmodule

// File: tb/sram_banked_bench.sv
module sram_banked_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 32;
    localparam int CW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rd_i = 1'b0;
    logic           wr_i = 1'b0;
    logic [14:0]    addr_i = '0;
    logic [31:0]    wdata_i = '0;
    logic [31:0]    rdata_o;
    logic           err_o;
    logic [NB*CW-1:0] act_cnt_o;

    sram_banked u_sram_banked (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (rd_i),
        .wr_i      (wr_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .err_o     (err_o),
        .act_cnt_o (act_cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] model [int];
    logic [14:0] wlist [$];
    int          cnt_m [NB];
    logic [31:0] exp_rd = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cnt_mismatch();
        int m = 0;
        for (int b = 0; b < NB; b++) begin
            if (act_cnt_o[b*CW +: CW] !== CW'(cnt_m[b])) m++;
        end
        return m;
    endfunction

    function automatic logic [14:0] mk(input int bank, input int row, input int word);
        return {bank[4:0], row[6:0], word[2:0]};
    endfunction

    // One request, then idle; checks after capture and after completion
    task automatic do_op(input bit rd, input bit wr, input logic [14:0] a,
                         input logic [31:0] d, input string tag);
        logic [31:0] prev;
        prev = exp_rd;
        @(negedge clk);
        rd_i = rd; wr_i = wr; addr_i = a; wdata_i = d;
        @(negedge clk);
        rd_i = 0; wr_i = 0;
        chk("R7 err flag", {63'd0, err_o}, {63'd0, rd && wr});
        chk("R4 no early data", {32'd0, rdata_o}, {32'd0, prev});
        if (rd && wr) begin
        end else if (wr) begin
            model[int'(a)] = d;
            wlist.push_back(a);
            cnt_m[a[14:10]]++;
        end else if (rd) begin
            exp_rd = model[int'(a)];
            cnt_m[a[14:10]]++;
        end
        @(negedge clk);
        chk(tag, {32'd0, rdata_o}, {32'd0, exp_rd});
        chk("R6 counters", 64'(cnt_mismatch()), 64'd0);
        chk("R7 err cleared", {63'd0, err_o}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int b = 0; b < NB; b++) cnt_m[b] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rdata", {32'd0, rdata_o}, 64'd0);
        chk("R1 err", {63'd0, err_o}, 64'd0);
        chk("R1 counters", 64'(cnt_mismatch()), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 64'(cnt_mismatch()), 64'd0);

        // R3: fill a row, overwrite one word, read all eight
        for (int w = 0; w < 8; w++) do_op(0, 1, mk(31, 127, w), 32'hA000_0000 | w, "R5 write hold");
        do_op(0, 1, mk(31, 127, 3), 32'h1234_5678, "R5 write hold");
        for (int w = 0; w < 8; w++) do_op(1, 0, mk(31, 127, w), 0, "R3 word isolation");

        // R2: neighbours differing in one field each
        do_op(0, 1, mk(5, 9, 2), 32'h0000_0A01, "R5 write hold");
        do_op(0, 1, mk(6, 9, 2), 32'h0000_0B02, "R5 write hold");
        do_op(0, 1, mk(5, 10, 2), 32'h0000_0C03, "R5 write hold");
        do_op(0, 1, mk(5, 9, 3), 32'h0000_0D04, "R5 write hold");
        do_op(0, 1, mk(0, 0, 0), 32'hFFFF_0000, "R5 write hold");
        do_op(1, 0, mk(5, 9, 2), 0, "R2 bank field");
        do_op(1, 0, mk(6, 9, 2), 0, "R2 bank field");
        do_op(1, 0, mk(5, 10, 2), 0, "R2 row field");
        do_op(1, 0, mk(5, 9, 3), 0, "R2 word field");
        do_op(1, 0, mk(0, 0, 0), 0, "R2 lowest address");

        // R7: collision leaves memory, counters and read port alone
        do_op(1, 1, mk(5, 9, 2), 32'hDEAD_BEEF, "R7 rdata held");
        do_op(1, 1, mk(31, 127, 3), 32'h0BAD_F00D, "R7 rdata held");
        do_op(1, 0, mk(5, 9, 2), 0, "R7 memory untouched");
        do_op(1, 0, mk(31, 127, 3), 0, "R7 memory untouched");

        // R5: idle cycles keep the last word
        repeat (5) @(negedge clk);
        chk("R5 idle hold", {32'd0, rdata_o}, {32'd0, exp_rd});

        // Seeded random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [14:0] a;
            r = $urandom_range(0, 99);
            if (r < 10) begin
                a = 15'($urandom_range(0, 32767));
                do_op(1, 1, a, $urandom, "R7 random clash");
            end else if (r < 55 || wlist.size() == 0) begin
                a = 15'($urandom_range(0, 32767));
                do_op(0, 1, a, $urandom, "R5 random write");
            end else begin
                a = wlist[$urandom_range(0, wlist.size() - 1)];
                do_op(1, 0, a, 0, "R4 random read");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule